// File: doc/BRIEF.md
# OTP Calibration Shift-Register Controller

This block holds a 14-bit one-time-programmable calibration store. The store has three fields: a 5-bit voltage trim, an 8-bit default for the VPR register, and a seal bit. Every stored bit pairs a non-volatile cell with a flip-flop in a serial shift chain. The cells are never read or written directly. A read copies all cells into the chain in one cycle. A write first shifts the new bits into the chain one strobe at a time, then a transfer command ORs the chain into the cells.

Commands arrive as a 3-bit opcode with a valid strobe. Calibration mode gates the transfer into the cells. Once the seal cell is set, calibration mode cannot be entered again. The trim output stays at a neutral code until the enable command is given or calibration mode is active. This lets a shifted trim be tried on the output without programming it.

The VPR register takes its value from one of two sources: the default field held in the chain, or data written over the command interface.

Top module: `otp_cal_ctrl`

## Requirements
- R1: Reset has the following effects:
  - It clears the shift chain, the enable flag, the VPR register and calibration mode.
  - It leaves the non-volatile cells unchanged.
  - After reset, `trim_o` shows the neutral code 5'b10000 and `vpr_o` reads 0.
- R2: Each cycle with `shift_en_i` high moves the chain one place toward its MSB and puts `shift_bit_i` into bit 0. `shift_out_o` is chain bit 13. After 14 strobes, the chain is laid out as follows:
  - The first bit shifted sits in bit 13.
  - Bits 13..9 are the trim, MSB first.
  - Bits 8..1 are the VPR default.
  - Bit 0 is the seal.
- R3: Opcode 6 (read) copies every cell into its chain flip-flop at the next edge. A read takes priority over a shift strobe in the same cycle.
- R4: Opcode 7 (write) ORs the chain into the cells only while in calibration mode. Outside calibration mode it leaves every cell unchanged.
- R5: Cells are write-once from 0 to 1. A write never clears a cell bit that is already set.
- R6: Calibration mode is controlled as follows:
  - Opcode 1 enters calibration mode.
  - Opcode 2 leaves it.
  - While the seal cell reads 1, entry is refused.
  - Once the seal cell is 1, calibration mode drops at the next edge.
  - `sealed_o` shows the seal cell and can never return to 0.
- R7: `trim_o` shows chain bits 13..9 when the enable flag is set or calibration mode is active. Otherwise it shows the neutral code 5'b10000. Shifting without a write changes `trim_o` but leaves the cells unaltered.
- R8: Opcode 3 sets the enable flag, which stays set until reset.
- R9: Opcode 4 loads `vpr_o` from chain bits 8..1. Opcode 5 loads `vpr_o` from `cmd_data_i`. Each takes effect at the next edge, and the register holds between commands. Opcode 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Opcode (0 nop, 1 enter cal, 2 exit cal, 3 enable, 4 load default, 5 set VPR, 6 read, 7 write) |
| cmd_data_i | input | 8 | Data for set VPR |
| shift_en_i | input | 1 | Shift strobe, one bit per cycle |
| shift_bit_i | input | 1 | Serial data into chain bit 0 |
| shift_out_o | output | 1 | Chain tail (bit 13) |
| trim_o | output | 5 | Effective voltage trim |
| vpr_o | output | 8 | VPR register |
| sealed_o | output | 1 | Seal cell state |
| cal_mode_o | output | 1 | Calibration mode active |

## Verification
The bench issues a write outside calibration mode and then reads the cells back. A design that does not gate the transfer would show the shifted pattern in the cells.

It writes a second pattern over already-set bits and expects their OR. A design that overwrote the cells instead of ORing would lose the earlier ones.

It asserts a read and a shift strobe in the same cycle. It also seals the part and then tries to re-enter calibration mode and to write. A wrong priority would leave a shifted chain. A leaky seal would raise `cal_mode_o` again or alter the cells.

Finally it resets after sealing. A design that cleared the cells on reset would lose both the seal and the programmed trim.

// File: rtl/otp_cal_pkg.sv
package otp_cal_pkg;
  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_ENTER_CAL = 3'd1,
    OP_EXIT_CAL  = 3'd2,
    OP_ENABLE    = 3'd3,
    OP_LOAD_DEF  = 3'd4,
    OP_SET_VPR   = 3'd5,
    OP_READ      = 3'd6,
    OP_WRITE     = 3'd7
  } otp_op_e;
endpackage

// File: rtl/otp_shift_chain.sv
module otp_shift_chain #(
  parameter int N = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] load_data_i,
  input  logic         shift_i,
  input  logic         shift_bit_i,
  output logic [N-1:0] chain_o,
  output logic         shift_out_o
);
  logic [N-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chain_q <= '0;
    else if (load_i)  chain_q <= load_data_i;  // read beats shift
    else if (shift_i) chain_q <= {chain_q[N-2:0], shift_bit_i};
  end

  assign chain_o     = chain_q;
  assign shift_out_o = chain_q[N-1];

  p_shift_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (shift_out_o == $past(chain_q[N-2])) && (chain_q[0] == $past(shift_bit_i)));
  p_read_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> chain_q == $past(load_data_i));
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int           N    = 14,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         prog_i,
  input  logic [N-1:0] prog_data_i,
  output logic [N-1:0] cells_o
);
  // non-volatile: no reset
  logic [N-1:0] cells_q = INIT;

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N; i++) begin
      if (prog_i && prog_data_i[i]) cells_q[i] <= 1'b1;
    end
  end

  assign cells_o = cells_q;

  p_write_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cells_q & $past(cells_q)) == $past(cells_q)));
  p_seal_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cells_q[0] |=> cells_q[0]);
endmodule

// File: rtl/otp_cal_ctrl.sv
module otp_cal_ctrl
  import otp_cal_pkg::*;
#(
  parameter int                TRIM_W       = 5,
  parameter int                VPR_W        = 8,
  parameter logic [TRIM_W-1:0] TRIM_NEUTRAL = 5'b10000,
  parameter logic [TRIM_W+VPR_W:0] CELL_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [VPR_W-1:0]  cmd_data_i,
  input  logic              shift_en_i,
  input  logic              shift_bit_i,
  output logic              shift_out_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic [VPR_W-1:0]  vpr_o,
  output logic              sealed_o,
  output logic              cal_mode_o
);
  localparam int N        = TRIM_W + VPR_W + 1;
  localparam int VPR_LSB  = 1;
  localparam int SEAL_IDX = 0;

  otp_op_e      op;
  logic         do_read, do_write, prog;
  logic [N-1:0] chain, cells;
  logic         cal_q, en_q;
  logic [VPR_W-1:0] vpr_q;

  assign op       = otp_op_e'(cmd_op_i);
  assign do_read  = cmd_valid_i && (op == OP_READ);
  assign do_write = cmd_valid_i && (op == OP_WRITE);
  assign prog     = do_write && cal_q;

  otp_shift_chain #(.N(N)) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (do_read),
    .load_data_i (cells),
    .shift_i     (shift_en_i),
    .shift_bit_i (shift_bit_i),
    .chain_o     (chain),
    .shift_out_o (shift_out_o)
  );

  otp_cell_array #(.N(N), .INIT(CELL_INIT)) u_cells (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_i      (prog),
    .prog_data_i (chain),
    .cells_o     (cells)
  );

  assign sealed_o = cells[SEAL_IDX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q <= 1'b0;
      en_q  <= 1'b0;
      vpr_q <= '0;
    end else begin
      if (sealed_o)                                cal_q <= 1'b0;
      else if (cmd_valid_i && op == OP_ENTER_CAL)  cal_q <= 1'b1;
      else if (cmd_valid_i && op == OP_EXIT_CAL)   cal_q <= 1'b0;

      if (cmd_valid_i && op == OP_ENABLE) en_q <= 1'b1;

      if (cmd_valid_i && op == OP_LOAD_DEF)     vpr_q <= chain[VPR_LSB +: VPR_W];
      else if (cmd_valid_i && op == OP_SET_VPR) vpr_q <= cmd_data_i;
    end
  end

  assign cal_mode_o = cal_q;
  assign vpr_o      = vpr_q;
  assign trim_o     = (en_q || cal_q) ? chain[N-1 -: TRIM_W] : TRIM_NEUTRAL;

  p_no_write_outside_cal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_write && !cal_mode_o) |=> cells == $past(cells));
  p_seal_blocks_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sealed_o && cmd_valid_i && op == OP_ENTER_CAL) |=> !cal_mode_o);
  p_load_default_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op == OP_LOAD_DEF) |=> vpr_o == $past(chain[VPR_LSB +: VPR_W]));
  p_set_vpr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op == OP_SET_VPR) |=> vpr_o == $past(cmd_data_i));
  p_enable_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
endmodule

// File: tb/otp_cal_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_cal_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic       shift_en = 1'b0;
  logic       shift_bit = 1'b0;
  logic       shift_out;
  logic [4:0] trim;
  logic [7:0] vpr;
  logic       sealed;
  logic       cal_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  otp_cal_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .shift_en_i(shift_en), .shift_bit_i(shift_bit),
    .shift_out_o(shift_out), .trim_o(trim), .vpr_o(vpr), .sealed_o(sealed),
    .cal_mode_o(cal_mode)
  );

  localparam logic [2:0] NOP = 3'd0, ENTER = 3'd1, EXIT = 3'd2, ENA = 3'd3,
                         LDEF = 3'd4, SETV = 3'd5, RD = 3'd6, WR = 3'd7;
  localparam logic [4:0]  NEUTRAL = 5'b10000;
  localparam logic [13:0] PAT_A = {5'b10110, 8'hCA, 1'b0};
  localparam logic [13:0] PAT_B = {5'b00001, 8'h01, 1'b0};
  localparam logic [13:0] PAT_S = 14'b1;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] data;
    logic [7:0] exp;
  } vec_t;

  // R9 vectors, run with PAT_A in the chain
  localparam vec_t VECS [5] = '{
    '{LDEF, 8'h00, 8'hCA},
    '{SETV, 8'h5A, 8'h5A},
    '{NOP,  8'h00, 8'h5A},
    '{LDEF, 8'h33, 8'hCA},
    '{SETV, 8'hFF, 8'hFF}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = NOP; cmd_data = '0;
  endtask

  task automatic shift_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) begin
      shift_en = 1'b1; shift_bit = w[i];
      @(negedge clk);
    end
    shift_en = 1'b0; shift_bit = 1'b0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 trim", trim, NEUTRAL);
    chk("R1 vpr", vpr, 0);
    chk("R1 cal", cal_mode, 0);
    chk("R1 sealed", sealed, 0);
    chk("R1 shift_out", shift_out, 0);

    // R2 shift, R7 not enabled yet
    shift_word(PAT_A);
    chk("R2 shift_out msb", shift_out, 1);
    chk("R7 trim neutral before enable", trim, NEUTRAL);

    // R9 table
    foreach (VECS[k]) begin
      cmd(VECS[k].op, VECS[k].data);
      chk("R9 vpr vector", vpr, VECS[k].exp);
    end

    // R8/R7 enable exposes chain trim; R2 layout
    cmd(ENA, 8'h00);
    chk("R8 trim after enable", trim, 5'b10110);

    // R4 write outside cal mode
    cmd(WR, 8'h00);
    shift_word('0);
    chk("R7 trim follows shifted zeros", trim, 0);
    cmd(RD, 8'h00);
    chk("R4 cells untouched outside cal", trim, 0);
    cmd(LDEF, 8'h00);
    chk("R4 vpr default untouched", vpr, 0);

    // R6 enter, R4 write in cal, R3 readback
    cmd(ENTER, 8'h00);
    chk("R6 cal entered", cal_mode, 1);
    shift_word(PAT_A);
    cmd(WR, 8'h00);
    shift_word('0);
    cmd(RD, 8'h00);
    chk("R3 read trim", trim, 5'b10110);
    cmd(LDEF, 8'h00);
    chk("R3 read vpr default", vpr, 8'hCA);

    // R5 OR semantics
    shift_word(PAT_B);
    cmd(WR, 8'h00);
    shift_word('0);
    cmd(RD, 8'h00);
    chk("R5 trim OR", trim, 5'b10111);
    cmd(LDEF, 8'h00);
    chk("R5 vpr OR", vpr, 8'hCB);

    // R7 shifting without write leaves cells
    cmd(EXIT, 8'h00);
    chk("R6 cal exited", cal_mode, 0);
    shift_word(14'h3FFE);
    chk("R7 trim shows trial", trim, 5'b11111);
    shift_word('0);
    cmd(RD, 8'h00);
    chk("R7 cells unaltered by trial", trim, 5'b10111);

    // R3 read beats shift
    shift_word('0);
    shift_en = 1'b1; shift_bit = 1'b1;
    cmd(RD, 8'h00);
    shift_en = 1'b0; shift_bit = 1'b0;
    chk("R3 read priority", trim, 5'b10111);

    // R6 sealing
    cmd(ENTER, 8'h00);
    shift_word(PAT_S);
    cmd(WR, 8'h00);
    chk("R6 sealed set", sealed, 1);
    @(negedge clk);
    chk("R6 cal dropped after seal", cal_mode, 0);
    cmd(ENTER, 8'h00);
    chk("R6 entry refused", cal_mode, 0);
    shift_word(14'h3FFE);
    cmd(WR, 8'h00);
    shift_word('0);
    cmd(RD, 8'h00);
    chk("R4 sealed write ignored", trim, 5'b10111);

    // R1 reset keeps cells
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 trim neutral after reset", trim, NEUTRAL);
    chk("R1 vpr zero after reset", vpr, 0);
    chk("R1 seal kept", sealed, 1);
    cmd(RD, 8'h00);
    cmd(ENA, 8'h00);
    chk("R1 cells kept", trim, 5'b10111);
    cmd(LDEF, 8'h00);
    chk("R1 vpr default kept", vpr, 8'hCB);

    done = 1'b1;
    report();
    $finish;
  end
endmodule